// File: doc/BRIEF.md
# Reset Priority and Strap Latch

This block turns three active-low asynchronous reset pins into three nested internal reset tiers. The pins are power-on, power-fail and user reset. The tiers are a full power-on reset, a system reset and a standby reset. The power-on tier is the only reset for always-on state, such as the real-time clock counter and its compare register. That state therefore survives power-fail and user resets. The system tier drives every other domain. The standby tier, together with a `run` indication, keeps the main-clock peripherals disabled while the chip is in its standby power state.

At the moment the power-on tier releases, the block captures two strap values. The first is the clock-mode pin, which selects external-clock or PLL clocking. The second is the level of the user-reset pin, which is held as a test-mode request. Both values then stay frozen until the next power-on reset, so both pins are free for other uses afterwards.

The block also keeps a start-up reason word for a status read path. This word holds a cold-start flag and flags that record power-fail and user resets. Software clears the word with a write strobe.

All tiers assert asynchronously and release synchronously to the slow always-on clock `clk`.

Top module: `reset_strap_ctrl`

## Requirements
- R1: `sys_rst_n` goes low as soon as any of `por_n`, `pfail_n` or `urst_n` goes low, without waiting for a clock edge.
- R2: While `por_rst_n` is low, `sys_rst_n`, `stby_rst_n` and `run` are also low. `por_rst_n` goes low at once when `por_n` goes low.
- R3: After a reset pin returns high, its tier's output stays low through the first rising `clk` edge and goes high on the SYNC_STAGES-th rising edge (the second edge with the default of 2).
- R4: `por_rst_n` is not affected by `pfail_n` or `urst_n`. Once released, it stays high while `por_n` stays high.
- R5: `ext_clk_mode` holds the value that `clkmode_pin` had at the clock edge on which `por_rst_n` rises. 1 means external-clock mode and 0 means PLL mode. Later changes of the pin, and system resets, leave it unchanged.
- R6: `test_req` is 1 exactly when `urst_n` was low at the clock edge on which `por_rst_n` rises. It is not changed by user resets at any other time.
- R7: Outside system reset, `stby_rst_n` and `run` are high and take the value `!stby_req` from each rising clock edge. Inside system reset, both are low.
- R8: While the power-on tier is active, `start_flags` reads 16'h8000: the cold-start flag is bit 15 and every other bit is 0.
- R9: While the power-fail tier is active, bit 1 of `start_flags` is set. While the user-reset tier is active, bit 2 is set. Each bit stays set until it is cleared.
- R10: A `flag_clr` pulse clears `start_flags` on the next edge. A clear never sets bit 15. When a flag's reset tier is active in the same cycle as a clear, that flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| pfail_n | input | 1 | Power-fail reset pin, active low, asynchronous |
| urst_n | input | 1 | User reset pin, active low, asynchronous; its level at power-on release is the test-mode strap |
| clkmode_pin | input | 1 | Clock-mode strap pin, sampled at power-on release |
| stby_req | input | 1 | High while the chip is in its standby power state |
| flag_clr | input | 1 | One-cycle write strobe that clears the start-up reason flags |
| por_rst_n | output | 1 | Full power-on reset tier, also used as the always-on (clock counter) reset |
| sys_rst_n | output | 1 | System reset tier |
| stby_rst_n | output | 1 | Standby reset tier for main-clock peripherals |
| run | output | 1 | High when the main clock domain is running |
| ext_clk_mode | output | 1 | Latched clock-mode strap: 1 selects external clock, 0 selects PLL |
| test_req | output | 1 | Latched test-mode request |
| start_flags | output | 16 | Start-up reason word: bit 15 cold start, bit 2 user reset, bit 1 power fail |

## Verification
Two functions can act on the flag word in the same cycle: a software clear and a flag set by an active power-fail or user-reset tier. The bench holds `pfail_n` low and pulses `flag_clr` during that time. Bit 1 must still read 1 after the clear. After the pin is released, a second clear must empty the word without raising the cold-start flag.

A second coincidence is the strap capture edge and a pin change. The bench changes `clkmode_pin` and `urst_n` right after the clock edge that releases power-on reset. It then checks that the captured values are the ones present at that edge.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
   parameter int FLAG_W    = 16;
   parameter int COLD_BIT  = 15;
   parameter int PFAIL_BIT = 1;
   parameter int URST_BIT  = 2;

   typedef logic [FLAG_W-1:0] flag_word_t;

   parameter flag_word_t FLAGS_AT_POR = flag_word_t'(1) << COLD_BIT;

   // strap vector positions
   parameter int STRAP_W       = 2;
   parameter int STRAP_CLKMODE = 0;
   parameter int STRAP_TEST    = 1;
endpackage

// File: rtl/rstctl_sync.sv
module rstctl_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstctl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
   end

   assign rst_n = chain_q[STAGES-1];

   // R3: a tier can only release after its source pin has been high
   assert_release_after_input_R3: assert property (
      @(posedge clk) disable iff (!arst_n)
      $rose(rst_n) |-> $past(arst_n)
   );
endmodule

// File: rtl/rstctl_strap.sv
module rstctl_strap #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         por_rst_n,
   input  logic [W-1:0] pin_i,
   output logic [W-1:0] held_o
);
   if (W < 1) begin : g_bad_width
      $error("rstctl_strap: W must be positive");
   end

   logic [W-1:0] held_q;

   // Tracks the pins while power-on reset is active; the edge on which the
   // tier releases is the last load, so the value present there is kept.
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!por_rst_n) held_q[i] <= pin_i[i];
      end
   end

   assign held_o = held_q;

   // R5 / R6: straps frozen once power-on reset has released
   assert_strap_frozen_R5: assert property (
      @(posedge clk) disable iff (!por_rst_n)
      $past(por_rst_n) |-> $stable(held_o)
   );
endmodule

// File: rtl/rstctl_flags.sv
module rstctl_flags
   import rstctl_pkg::*;
(
   input  logic       clk,
   input  logic       por_rst_n,
   input  logic       clr_i,
   input  logic       pf_act_i,
   input  logic       ur_act_i,
   output flag_word_t flags_o
);
   flag_word_t flags_q, flags_d;

   always_comb begin
      flags_d = clr_i ? '0 : flags_q;
      if (pf_act_i) flags_d[PFAIL_BIT] = 1'b1;
      if (ur_act_i) flags_d[URST_BIT]  = 1'b1;
   end

   always_ff @(posedge clk or negedge por_rst_n) begin
      if (!por_rst_n) flags_q <= FLAGS_AT_POR;
      else            flags_q <= flags_d;
   end

   assign flags_o = flags_q;

   // R10: cold flag never re-appears after power-on reset
   assert_cold_not_set_R10: assert property (
      @(posedge clk) disable iff (!por_rst_n)
      !$past(flags_o[COLD_BIT]) |-> !flags_o[COLD_BIT]
   );

   // R10: a clear with no active source empties the word
   assert_clear_empties_R10: assert property (
      @(posedge clk) disable iff (!por_rst_n)
      (clr_i && !pf_act_i && !ur_act_i) |=> (flags_o == '0)
   );

   // R9: an active power-fail tier leaves its flag set, clear or not
   assert_pfail_flag_R9: assert property (
      @(posedge clk) disable iff (!por_rst_n)
      pf_act_i |=> flags_o[PFAIL_BIT]
   );
endmodule

// File: rtl/reset_strap_ctrl.sv
module reset_strap_ctrl
   import rstctl_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              pfail_n,
   input  logic              urst_n,
   input  logic              clkmode_pin,
   input  logic              stby_req,
   input  logic              flag_clr,
   output logic              por_rst_n,
   output logic              sys_rst_n,
   output logic              stby_rst_n,
   output logic              run,
   output logic              ext_clk_mode,
   output logic              test_req,
   output logic [FLAG_W-1:0] start_flags
);
   if (COLD_BIT >= FLAG_W || PFAIL_BIT >= FLAG_W || URST_BIT >= FLAG_W) begin : g_bad_bits
      $error("reset_strap_ctrl: flag position outside the word");
   end
   if (PFAIL_BIT == URST_BIT || PFAIL_BIT == COLD_BIT || URST_BIT == COLD_BIT) begin : g_dup_bits
      $error("reset_strap_ctrl: flag positions overlap");
   end

   logic por_q, sys_q, pf_q, ur_q;
   logic sys_src_n;
   logic awake_q;
   logic [STRAP_W-1:0] strap_pins, strap_held;

   assign sys_src_n = por_n & pfail_n & urst_n;

   rstctl_sync #(.STAGES(SYNC_STAGES)) u_por_sync (.clk(clk), .arst_n(por_n),     .rst_n(por_q));
   rstctl_sync #(.STAGES(SYNC_STAGES)) u_sys_sync (.clk(clk), .arst_n(sys_src_n), .rst_n(sys_q));
   rstctl_sync #(.STAGES(SYNC_STAGES)) u_pf_sync  (.clk(clk), .arst_n(pfail_n),   .rst_n(pf_q));
   rstctl_sync #(.STAGES(SYNC_STAGES)) u_ur_sync  (.clk(clk), .arst_n(urst_n),    .rst_n(ur_q));

   assign por_rst_n = por_q;
   assign sys_rst_n = sys_q;

   // standby tier: held low through system reset, then follows power state
   always_ff @(posedge clk or negedge sys_q) begin
      if (!sys_q) awake_q <= 1'b0;
      else        awake_q <= !stby_req;
   end

   assign stby_rst_n = awake_q;
   assign run        = awake_q;

   assign strap_pins[STRAP_CLKMODE] = clkmode_pin;
   assign strap_pins[STRAP_TEST]    = !urst_n;

   rstctl_strap #(.W(STRAP_W)) u_strap (
      .clk      (clk),
      .por_rst_n(por_q),
      .pin_i    (strap_pins),
      .held_o   (strap_held)
   );

   assign ext_clk_mode = strap_held[STRAP_CLKMODE];
   assign test_req     = strap_held[STRAP_TEST];

   rstctl_flags u_flags (
      .clk      (clk),
      .por_rst_n(por_q),
      .clr_i    (flag_clr),
      .pf_act_i (!pf_q),
      .ur_act_i (!ur_q),
      .flags_o  (start_flags)
   );

   // R1: any active source pin holds the system tier
   assert_any_source_resets_sys_R1: assert property (
      @(posedge clk) disable iff (!por_n)
      (!pfail_n || !urst_n) |-> !sys_rst_n
   );

   // R2: power-on tier forces the lower tiers
   assert_por_nests_R2: assert property (
      @(posedge clk) disable iff (por_n === 1'bx)
      !por_rst_n |-> (!sys_rst_n && !stby_rst_n && !run)
   );

   // R4: power-fail and user reset never touch the power-on tier
   assert_por_survives_R4: assert property (
      @(posedge clk) disable iff (!por_n)
      $past(por_rst_n) |-> por_rst_n
   );

   // R7: standby request drops the standby tier one edge later
   assert_standby_drop_R7: assert property (
      @(posedge clk) disable iff (!sys_rst_n)
      stby_req |=> !stby_rst_n
   );
endmodule

// File: tb/sim_reset_strap_ctrl.sv
`timescale 1ns/1ps
module sim_reset_strap_ctrl;
   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic por_n, pfail_n, urst_n, clkmode_pin, stby_req, flag_clr;
   logic por_rst_n, sys_rst_n, stby_rst_n, run, ext_clk_mode, test_req;
   logic [15:0] start_flags;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   reset_strap_ctrl u0 (
      .clk(clk), .por_n(por_n), .pfail_n(pfail_n), .urst_n(urst_n),
      .clkmode_pin(clkmode_pin), .stby_req(stby_req), .flag_clr(flag_clr),
      .por_rst_n(por_rst_n), .sys_rst_n(sys_rst_n), .stby_rst_n(stby_rst_n),
      .run(run), .ext_clk_mode(ext_clk_mode), .test_req(test_req),
      .start_flags(start_flags)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic pulse_clear();
      @(negedge clk) flag_clr = 1'b1;
      @(negedge clk) flag_clr = 1'b0;
   endtask

   task automatic t_reset_state();
      cyc(3);
      chk("R2 por_rst_n low", {15'd0, por_rst_n}, 16'd0);
      chk("R2 sys_rst_n low", {15'd0, sys_rst_n}, 16'd0);
      chk("R2 stby_rst_n low", {15'd0, stby_rst_n}, 16'd0);
      chk("R2 run low", {15'd0, run}, 16'd0);
      chk("R8 flags at power-on", start_flags, 16'h8000);
   endtask

   task automatic t_power_on(input logic strap, input logic urst_lvl);
      @(negedge clk);
      por_n = 1'b0; clkmode_pin = strap; urst_n = urst_lvl;
      #1 chk("R2 por asserts at once", {15'd0, por_rst_n}, 16'd0);
      cyc(3);
      chk("R8 flags during power-on", start_flags, 16'h8000);
      por_n = 1'b1;
      cyc(1);
      chk("R3 por still low after first edge", {15'd0, por_rst_n}, 16'd0);
      cyc(1);
      chk("R3 por released on second edge", {15'd0, por_rst_n}, 16'd1);
      clkmode_pin = ~strap; urst_n = 1'b1;   // change straps right after capture
      cyc(6);
      chk("R5 clock mode strap", {15'd0, ext_clk_mode}, {15'd0, strap});
      chk("R6 test request strap", {15'd0, test_req}, {15'd0, ~urst_lvl});
      chk("R3 sys released", {15'd0, sys_rst_n}, 16'd1);
      chk("R7 standby tier high", {15'd0, stby_rst_n}, 16'd1);
      chk("R7 run high", {15'd0, run}, 16'd1);
      chk("R9 flags after power-on", start_flags, urst_lvl ? 16'h8000 : 16'h8004);
   endtask

   task automatic t_power_fail();
      pulse_clear();
      chk("R10 clear removes cold flag", start_flags, 16'h0000);
      pfail_n = 1'b0;
      #1 chk("R1 power-fail asserts sys at once", {15'd0, sys_rst_n}, 16'd0);
      chk("R4 por unaffected by power-fail", {15'd0, por_rst_n}, 16'd1);
      cyc(3);
      chk("R7 run low in sys reset", {15'd0, run}, 16'd0);
      chk("R7 standby tier low in sys reset", {15'd0, stby_rst_n}, 16'd0);
      pulse_clear();
      chk("R10 active set beats clear", start_flags, 16'h0002);
      pfail_n = 1'b1;
      cyc(6);
      chk("R3 sys released after power-fail", {15'd0, sys_rst_n}, 16'd1);
      chk("R9 power-fail flag kept", start_flags, 16'h0002);
      chk("R5 strap survives power-fail", {15'd0, ext_clk_mode}, 16'd1);
      pulse_clear();
      chk("R10 clear without source", start_flags, 16'h0000);
   endtask

   task automatic t_user_reset();
      urst_n = 1'b0;
      #1 chk("R1 user reset asserts sys at once", {15'd0, sys_rst_n}, 16'd0);
      chk("R4 por unaffected by user reset", {15'd0, por_rst_n}, 16'd1);
      cyc(3);
      urst_n = 1'b1;
      cyc(6);
      chk("R6 user reset later sets no test request", {15'd0, test_req}, 16'd0);
      chk("R9 user reset flag", start_flags, 16'h0004);
      chk("R3 sys released after user reset", {15'd0, sys_rst_n}, 16'd1);
      pulse_clear();
      chk("R10 clear user flag", start_flags, 16'h0000);
   endtask

   task automatic t_standby();
      @(negedge clk) stby_req = 1'b1;
      cyc(1);
      chk("R7 standby tier drops", {15'd0, stby_rst_n}, 16'd0);
      chk("R7 run drops in standby", {15'd0, run}, 16'd0);
      chk("R7 sys stays released", {15'd0, sys_rst_n}, 16'd1);
      stby_req = 1'b0;
      cyc(1);
      chk("R7 standby tier returns", {15'd0, stby_rst_n}, 16'd1);
      chk("R7 run returns", {15'd0, run}, 16'd1);
   endtask

   initial begin
      por_n = 1'b0; pfail_n = 1'b1; urst_n = 1'b1;
      clkmode_pin = 1'b1; stby_req = 1'b0; flag_clr = 1'b0;
      t_reset_state();
      t_power_on(1'b0, 1'b0);
      t_power_on(1'b1, 1'b1);
      t_power_fail();
      t_user_reset();
      t_standby();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule